// File: doc/BRIEF.md
# Phase-Split Two-Read One-Write Register File

This block is the operand store for a pipelined core that must fetch two source operands and retire one result in every processor cycle. The storage behind it can serve either a pair of single-ended reads or a single write at any instant, never both. To get the full three accesses per cycle, each processor cycle is cut into two halves: the read half, in which both read addresses are looked up, and the write half, in which the result is committed.

The block runs on a clock at twice the processor rate. An internal phase bit toggles on every edge of that clock and is brought out as `phase_o` so that the surrounding pipeline can align to it. The pipeline presents its read addresses and write request at the start of a processor cycle, that is, while `phase_o` is 0, and holds them for both halves. Read data is registered at the end of the read half and stays put through the write half. Because the write lands after the reads, a read in the same processor cycle as a write to the same register sees the old contents, and a read one cycle later sees the new contents. Register 0 is a constant zero.

Top module: `tmrf_regfile`

## Requirements
- R1: While `rst_n` is low, `phase_o` is 0, both read data outputs are 0 and every register holds 0; after release the first edge is a read edge.
- R2: After reset `phase_o` alternates on every `clk` rising edge; 0 marks the read half and 1 marks the write half of a processor cycle.
- R3: On the rising edge taken while `phase_o` is 0, `rd_data_a` and `rd_data_b` load the contents of the registers at `rd_addr_a` and `rd_addr_b`.
- R4: Read data does not change on the rising edge taken while `phase_o` is 1, so it is valid for the whole write half.
- R5: On the rising edge taken while `phase_o` is 1, if `wr_en` is 1 and `wr_addr` is nonzero, the register at `wr_addr` takes `wr_data`.
- R6: A read in the same processor cycle as a write to the same register returns the value held before the write.
- R7: A read in the processor cycle after a write to a register returns the newly written value.
- R8: Address 0 always reads as 0, and writes to address 0 have no effect.
- R9: `wr_en`, `wr_addr` and `wr_data` are ignored on the read edge; a write request removed before the write edge leaves the register file unchanged.
- R10: The two read ports are independent; both ports may name the same register and then return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; two rising edges form one processor cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_o | output | 1 | Current half: 0 read half, 1 write half |
| rd_addr_a | input | 5 | Register index for read port A |
| rd_data_a | output | 32 | Read port A data, registered at the read edge |
| rd_addr_b | input | 5 | Register index for read port B |
| rd_data_b | output | 32 | Read port B data, registered at the read edge |
| wr_en | input | 1 | Write request, sampled at the write edge |
| wr_addr | input | 5 | Register index for the write |
| wr_data | input | 32 | Value to write |

## Verification
The properties assume the pipeline holds its read address, write enable, write address and write data unchanged across both halves of a processor cycle and only changes them at the start of a read half; the write-through property relates a write edge to the following read edge on that basis. The bench keeps to this by changing inputs only on falling edges that precede a read edge, with the single deliberate exception of the test that drops a write request between the two halves, which no property depends on. Expected read values come from a bench-side array of 32 registers updated after each processor cycle's reads are checked.

// File: rtl/tmrf_pkg.sv
package tmrf_pkg;

    typedef enum logic {
        PH_READ  = 1'b0,
        PH_WRITE = 1'b1
    } tmrf_phase_e;

    // number of read ports the file offers
    localparam int unsigned TMRF_NRD = 2;

endpackage

// File: rtl/tmrf_phase.sv
module tmrf_phase
    import tmrf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic rd_slot,
    output logic wr_slot,
    output logic phase
);

    typedef struct packed {
        tmrf_phase_e ph;
    } phase_state_t;

    phase_state_t st_d;
    phase_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.ph == PH_READ) begin
            st_d.ph = PH_WRITE;
        end else begin
            st_d.ph = PH_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_READ};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_slot = (st_q.ph == PH_READ);
    assign wr_slot = (st_q.ph == PH_WRITE);
    assign phase   = st_q.ph;

endmodule

// File: rtl/tmrf_array.sv
module tmrf_array
    import tmrf_pkg::*;
#(
    parameter int unsigned NREG = 32,
    parameter int unsigned DW   = 32,
    parameter int unsigned NRD  = TMRF_NRD,
    localparam int unsigned AW  = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  logic [NRD-1:0][AW-1:0] rd_idx,
    output logic [NRD-1:0][DW-1:0] rd_val,
    input  logic                   wr_go,
    input  logic [AW-1:0]          wr_idx,
    input  logic [DW-1:0]          wr_val
);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] cells;
        logic [NRD-1:0][DW-1:0]  rd;
    } arr_state_t;

    arr_state_t st_d;
    arr_state_t st_q;

    logic [NRD-1:0][DW-1:0] lookup;

    // one lookup path per read port; index 0 is a constant zero
    for (genvar p = 0; p < NRD; p++) begin : g_rport
        always_comb begin
            if (rd_idx[p] == '0) begin
                lookup[p] = '0;
            end else begin
                lookup[p] = st_q.cells[rd_idx[p]];
            end
        end
    end

    // the array either reads (both ports) or writes, never both in one edge
    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.rd = lookup;
        end else if (wr_go && (wr_idx != '0)) begin
            st_d.cells[wr_idx] = wr_val;
        end
        st_d.cells[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_val = st_q.rd;

endmodule

// File: rtl/tmrf_regfile.sv
module tmrf_regfile
    import tmrf_pkg::*;
#(
    parameter int unsigned NREG = 32,
    parameter int unsigned DW   = 32,
    localparam int unsigned AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          phase_o,
    input  logic [AW-1:0] rd_addr_a,
    output logic [DW-1:0] rd_data_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [DW-1:0] rd_data_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);

    logic rd_slot;
    logic wr_slot;
    logic ph;

    logic [TMRF_NRD-1:0][AW-1:0] rd_idx;
    logic [TMRF_NRD-1:0][DW-1:0] rd_val;
    logic                        wr_go;

    tmrf_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_slot (rd_slot),
        .wr_slot (wr_slot),
        .phase   (ph)
    );

    always_comb begin
        rd_idx    = '0;
        rd_idx[0] = rd_addr_a;
        rd_idx[1] = rd_addr_b;
    end

    // write request only reaches the array in the write half
    assign wr_go = wr_slot & wr_en;

    tmrf_array #(
        .NREG (NREG),
        .DW   (DW),
        .NRD  (TMRF_NRD)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_slot),
        .rd_idx (rd_idx),
        .rd_val (rd_val),
        .wr_go  (wr_go),
        .wr_idx (wr_addr),
        .wr_val (wr_data)
    );

    assign rd_data_a = rd_val[0];
    assign rd_data_b = rd_val[1];
    assign phase_o   = ph;

endmodule

// File: rtl/tmrf_regfile_chk.sv
module tmrf_regfile_chk #(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          phase_o,
    input logic [AW-1:0] rd_addr_a,
    input logic [DW-1:0] rd_data_a,
    input logic [AW-1:0] rd_addr_b,
    input logic [DW-1:0] rd_data_b,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data
);

    // R2: read half is always followed by a write half
    p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_o |=> phase_o);

    // R2: write half is always followed by a read half
    p_wr_then_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o |=> !phase_o);

    // R4: the write edge leaves read data untouched
    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o |=> ($stable(rd_data_a) && $stable(rd_data_b)));

    // R8: address 0 reads as zero on both ports
    p_zero_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_o && rd_addr_a == '0) |=> (rd_data_a == '0));

    p_zero_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_o && rd_addr_b == '0) |=> (rd_data_b == '0));

    // R7: a register written at a write edge is seen at the next read edge
    p_raw_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_o && $past(phase_o) && $past(wr_en) && ($past(wr_addr) != '0)
         && (rd_addr_a == $past(wr_addr)))
        |=> (rd_data_a == $past(wr_data, 2)));

endmodule

bind tmrf_regfile tmrf_regfile_chk #(
    .AW (AW),
    .DW (DW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_o   (phase_o),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_b (rd_data_b),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
);

// File: tb/tmrf_regfile_tb_top.sv
`timescale 1ns/1ps
module tmrf_regfile_tb_top;

    localparam int unsigned NREG = 32;
    localparam int unsigned DW   = 32;
    localparam int unsigned AW   = 5;
    localparam int NV = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          phase_o;
    logic [AW-1:0] rd_addr_a = '0;
    logic [DW-1:0] rd_data_a;
    logic [AW-1:0] rd_addr_b = '0;
    logic [DW-1:0] rd_data_b;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [DW-1:0] model [NREG];

    always #4 clk = ~clk;

    tmrf_regfile #(.NREG(NREG), .DW(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_o   (phase_o),
        .rd_addr_a (rd_addr_a),
        .rd_data_a (rd_data_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_b (rd_data_b),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    // stimulus table: read A, read B, write enable, write index, write value
    localparam logic [AW-1:0] V_RA [NV] = '{5'd1, 5'd1, 5'd2, 5'd2, 5'd0, 5'd31,
                                            5'd31, 5'd9, 5'd9, 5'd3, 5'd4, 5'd16};
    localparam logic [AW-1:0] V_RB [NV] = '{5'd2, 5'd1, 5'd1, 5'd0, 5'd31, 5'd0,
                                            5'd2, 5'd9, 5'd31, 5'd4, 5'd3, 5'd16};
    localparam logic          V_WE [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
                                            1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic [AW-1:0] V_WA [NV] = '{5'd1, 5'd2, 5'd2, 5'd0, 5'd31, 5'd31,
                                            5'd9, 5'd9, 5'd3, 5'd4, 5'd16, 5'd16};
    localparam logic [DW-1:0] V_WD [NV] = '{32'hA5A5_0001, 32'h0000_BEEF, 32'h1234_5678,
                                            32'hFFFF_FFFF, 32'h8000_0001, 32'h0000_DEAD,
                                            32'h0F0F_0F0F, 32'hCAFE_0009, 32'h3333_3333,
                                            32'h4444_4444, 32'h1616_1616, 32'h7777_7777};

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ref_read(input logic [AW-1:0] a);
        return (a == '0) ? '0 : model[a];
    endfunction

    // one processor cycle; entered and left on a falling edge in the read half
    task automatic run_cycle(input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                             input logic we, input logic [AW-1:0] wa,
                             input logic [DW-1:0] wd, input string req);
        check({31'd0, phase_o}, 32'd0, "R2 read half");
        rd_addr_a = ra;
        rd_addr_b = rb;
        wr_en     = we;
        wr_addr   = wa;
        wr_data   = wd;
        @(posedge clk);
        @(negedge clk);
        check({31'd0, phase_o}, 32'd1, "R2 write half");
        // reads see state before this cycle's write (R3, R6, R10)
        check(rd_data_a, ref_read(ra), {req, " port A"});
        check(rd_data_b, ref_read(rb), {req, " port B"});
        @(posedge clk);
        @(negedge clk);
        // R4: still the same after the write edge
        check(rd_data_a, ref_read(ra), "R4 hold A");
        if (we && wa != '0) model[wa] = wd;
        wr_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = '0;
        #30;
        // R1: values held during reset
        check({31'd0, phase_o}, 32'd0, "R1 phase in reset");
        check(rd_data_a, '0, "R1 port A in reset");
        check(rd_data_b, '0, "R1 port B in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // vector walk: R3 R5 R6 R7 R8 R10 exercised by rows 0..11
        // row1 reads reg1 after row0 wrote it (R7), both ports same (R10)
        // row2 reads reg2 while rewriting it (R6); row3 writes reg0 (R8)
        for (int v = 0; v < NV; v++) begin
            run_cycle(V_RA[v], V_RB[v], V_WE[v], V_WA[v], V_WD[v], "R3/R5/R6/R7 vector");
        end
        // R8: write of all ones to register 0 in row 3 left it zero
        run_cycle(5'd0, 5'd16, 1'b0, 5'd0, '0, "R8 zero after write");
        check(rd_data_a, '0, "R8 reg0 still zero");
        // R5: row 11 rewrote reg16
        check(rd_data_b, 32'h7777_7777, "R5 committed write");

        // R9: request raised in read half only, dropped before write edge
        check({31'd0, phase_o}, 32'd0, "R9 aligned");
        wr_en   = 1'b1;
        wr_addr = 5'd7;
        wr_data = 32'h0000_0077;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        run_cycle(5'd7, 5'd7, 1'b0, 5'd0, '0, "R9 no write");
        check(rd_data_a, '0, "R9 reg7 untouched");

        // R1: reset in the middle of operation clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check({31'd0, phase_o}, 32'd0, "R1 phase after reset");
        check(rd_data_a, '0, "R1 data after reset");
        for (int i = 0; i < NREG; i++) model[i] = '0;
        @(negedge clk);
        rst_n = 1'b1;
        run_cycle(5'd31, 5'd9, 1'b0, 5'd0, '0, "R1 registers cleared");
        check(rd_data_b, '0, "R1 reg9 cleared");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule